// File: doc/BRIEF.md
# Byte Queue Pair with Threshold and Idle-Timeout Interrupts

This block sits between a serial character engine and a processor. It holds two byte queues of 16 entries each. The receive queue is filled by the engine and drained by software. The transmit queue is filled by software and drained by the engine. Each queue compares its fill level against a 4-bit mark and raises a status bit when the mark is met. This lets software move data in blocks rather than one byte at a time.

A block shorter than the receive mark would never reach the threshold. An idle watchdog covers that case. Once triggered, it counts clock cycles while the receive queue holds data and no new byte arrives. When the count reaches a programmed limit, it raises a timeout status so that software collects the stragglers. The watchdog either fires once or reloads itself on every expiry.

Five status sources share one interrupt line. Each source has a raw bit, an enable bit and a write-1-to-clear pulse. Each queue also has its own flush control.

Top module: `byte_q_irq_top`

## Requirements
- R1: Each queue returns bytes in the order they were accepted. A pop of a non-empty queue presents the popped byte on its read-data port one cycle later, and that value is held until the next pop that takes effect.
- R2: A push to a queue holding 16 bytes is dropped and the level stays at 16. The overflow raw bit of that queue is set: bit 2 for receive, bit 3 for transmit.
- R3: A pop of an empty queue leaves the read data and the level unchanged.
- R4: Raw bit 0 (receive threshold) is set within two cycles whenever the receive level is at least the receive mark. A mark of 0 stands for 16. While the level is below the mark, bit 0 stays clear unless set earlier.
- R5: Raw bit 1 (transmit threshold) is set within two cycles whenever the transmit level is at most the transmit mark.
- R6: After a trigger pulse, raw bit 4 (receive timeout) is set once the receive queue has been non-empty with no accepted push for the programmed number of consecutive cycles.
- R7: Every accepted receive push restarts the timeout count from zero. While the receive queue is empty, or while it is being flushed, the count is held at zero and nothing fires.
- R8: With repeat off, the watchdog disarms after one expiry and fires no more until the next trigger pulse. With repeat on, it reloads and fires again after every further limit-length quiet interval.
- R9: A flush pulse on one direction empties that queue in the next cycle. It leaves that queue's read data and the other queue untouched, and a push in the same cycle is ignored.
- R10: The masked status is the raw status ANDed with the enable bits. The interrupt output is high exactly when any masked bit is high.
- R11: A clear pulse on a raw bit clears it in the next cycle unless that bit's set condition holds in the same cycle; if it does, the set wins.
- R12: During reset both levels are 0 and all raw status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_push | input | 1 | Write a byte into the receive queue |
| rx_wdata | input | 8 | Byte to write into the receive queue |
| rx_pop | input | 1 | Read a byte from the receive queue |
| rx_flush | input | 1 | Empty the receive queue |
| rx_rdata | output | 8 | Last byte read from the receive queue |
| rx_level | output | 5 | Receive queue fill level |
| tx_push | input | 1 | Write a byte into the transmit queue |
| tx_wdata | input | 8 | Byte to write into the transmit queue |
| tx_pop | input | 1 | Read a byte from the transmit queue |
| tx_flush | input | 1 | Empty the transmit queue |
| tx_rdata | output | 8 | Last byte read from the transmit queue |
| tx_level | output | 5 | Transmit queue fill level |
| rx_mark | input | 4 | Receive threshold (0 means 16) |
| tx_mark | input | 4 | Transmit threshold |
| wd_trigger | input | 1 | Arm the watchdog and zero its count |
| wd_repeat | input | 1 | Reload the watchdog after each expiry |
| wd_limit | input | 16 | Quiet cycles to expiry (0 never fires) |
| irq_en | input | 5 | Per-source enable |
| irq_clr | input | 5 | Per-source write-1-to-clear pulse |
| irq_raw | output | 5 | Raw status: 0 rx threshold, 1 tx threshold, 2 rx overflow, 3 tx overflow, 4 rx timeout |
| irq_masked | output | 5 | Raw status ANDed with enables |
| irq | output | 1 | OR of masked status |

## Verification
The properties take for granted that the control inputs hold their values across each clock edge. They also take for granted that a clear pulse on the overflow bit does not coincide with a push into a full queue. The stimulus changes every input on the falling clock edge only. It keeps push, pop and flush to one operation per side in any cycle, and issues clears only while the queue levels are steady. Quiet intervals in the watchdog tests sit at least five cycles away from the limit, so that the outcome does not hinge on a single cycle.

// File: rtl/bqi_pkg.sv
package bqi_pkg;
    localparam int NIRQ         = 5;
    localparam int IRQ_RX_FULL  = 0;
    localparam int IRQ_TX_EMPTY = 1;
    localparam int IRQ_RX_OVF   = 2;
    localparam int IRQ_TX_OVF   = 3;
    localparam int IRQ_RX_TOUT  = 4;
    typedef logic [NIRQ-1:0] irq_vec_t;
endpackage

// File: rtl/bqi_fifo.sv
module bqi_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    input  logic          flush,
    output logic [DW-1:0] rdata,
    output logic [LW-1:0] level,
    output logic          push_ok,
    output logic          push_drop
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [LW-1:0]            lvl;
        logic [DW-1:0]            rd;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic full_w, empty_w, do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        full_w  = (st_q.lvl == LW'(DEPTH));
        empty_w = (st_q.lvl == '0);
        do_push = push && !full_w && !flush;
        do_pop  = pop && !empty_w && !flush;
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.lvl = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wp] = wdata;
                st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + AW'(1);
            end
            if (do_pop) begin
                st_d.rd = st_q.mem[st_q.rp];
                st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + AW'(1);
            end
            st_d.lvl = st_q.lvl + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata     = st_q.rd;
    assign level     = st_q.lvl;
    assign push_ok   = do_push;
    assign push_drop = push && full_w && !flush;
endmodule

// File: rtl/bqi_wdog.sv
module bqi_wdog #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trigger,
    input  logic          repeat_en,
    input  logic [CW-1:0] limit,
    input  logic          restart,
    input  logic          idle,
    output logic          expire
);
    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
    } wd_st_t;

    wd_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (trigger) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
        end else if (st_q.armed) begin
            if (idle || restart) begin
                st_d.cnt = '0;
            end else if (limit != '0 && st_q.cnt == limit - CW'(1)) begin
                expire     = 1'b1;
                st_d.cnt   = '0;
                st_d.armed = repeat_en;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/byte_q_irq_top.sv
module byte_q_irq_top
    import bqi_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int WD_W  = 16,
    localparam int MW   = $clog2(DEPTH),
    localparam int LW   = MW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_push,
    input  logic [DW-1:0]   rx_wdata,
    input  logic            rx_pop,
    input  logic            rx_flush,
    output logic [DW-1:0]   rx_rdata,
    output logic [LW-1:0]   rx_level,
    input  logic            tx_push,
    input  logic [DW-1:0]   tx_wdata,
    input  logic            tx_pop,
    input  logic            tx_flush,
    output logic [DW-1:0]   tx_rdata,
    output logic [LW-1:0]   tx_level,
    input  logic [MW-1:0]   rx_mark,
    input  logic [MW-1:0]   tx_mark,
    input  logic            wd_trigger,
    input  logic            wd_repeat,
    input  logic [WD_W-1:0] wd_limit,
    input  logic [NIRQ-1:0] irq_en,
    input  logic [NIRQ-1:0] irq_clr,
    output logic [NIRQ-1:0] irq_raw,
    output logic [NIRQ-1:0] irq_masked,
    output logic            irq
);
    typedef struct packed {
        irq_vec_t raw;
    } top_st_t;

    top_st_t  st_d, st_q;
    logic     rx_ok, rx_drop, tx_ok, tx_drop, wd_fire;
    logic [LW-1:0] rx_thr;
    irq_vec_t set_w;

    bqi_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_wdata),
        .pop(rx_pop), .flush(rx_flush), .rdata(rx_rdata), .level(rx_level),
        .push_ok(rx_ok), .push_drop(rx_drop)
    );

    bqi_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_wdata),
        .pop(tx_pop), .flush(tx_flush), .rdata(tx_rdata), .level(tx_level),
        .push_ok(tx_ok), .push_drop(tx_drop)
    );

    bqi_wdog #(.CW(WD_W)) u_wdog (
        .clk(clk), .rst_n(rst_n), .trigger(wd_trigger), .repeat_en(wd_repeat),
        .limit(wd_limit), .restart(rx_ok),
        .idle((rx_level == '0) || rx_flush), .expire(wd_fire)
    );

    always_comb begin
        st_d   = st_q;
        rx_thr = (rx_mark == '0) ? LW'(DEPTH) : {1'b0, rx_mark};
        set_w  = '0;
        set_w[IRQ_RX_FULL]  = (rx_level >= rx_thr);
        set_w[IRQ_TX_EMPTY] = (tx_level <= {1'b0, tx_mark});
        set_w[IRQ_RX_OVF]   = rx_drop;
        set_w[IRQ_TX_OVF]   = tx_drop;
        set_w[IRQ_RX_TOUT]  = wd_fire;
        st_d.raw = (st_q.raw & ~irq_clr) | set_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_raw    = st_q.raw;
    assign irq_masked = st_q.raw & irq_en;
    assign irq        = |irq_masked;
endmodule

// File: rtl/bqi_chk.sv
module bqi_chk #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int NI    = 5,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_push,
    input logic          rx_pop,
    input logic          rx_flush,
    input logic [DW-1:0] rx_rdata,
    input logic [LW-1:0] rx_level,
    input logic [NI-1:0] irq_raw,
    input logic [NI-1:0] irq_clr,
    input logic          irq
);
    assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= LW'(DEPTH));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_flush && rx_level == LW'(DEPTH)) |=> irq_raw[2] && rx_level == LW'(DEPTH));

    assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !rx_push && !rx_flush && rx_level == '0) |=> $stable(rx_rdata) && rx_level == '0);

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> rx_level == '0 && $stable(rx_rdata));

    assert_push_counts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_pop && !rx_flush && rx_level < LW'(DEPTH)) |=> rx_level == $past(rx_level) + LW'(1));

    assert_raw_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_raw[0] && !irq_clr[0]) |=> irq_raw[0]);

    assert_ovf_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr[2] && !(rx_push && rx_level == LW'(DEPTH))) |=> !irq_raw[2]);

    assert_irq_needs_raw_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_raw != '0));
endmodule

bind byte_q_irq_top bqi_chk #(.DEPTH(DEPTH), .DW(DW), .NI(bqi_pkg::NIRQ)) u_bqi_chk (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_pop(rx_pop),
    .rx_flush(rx_flush), .rx_rdata(rx_rdata), .rx_level(rx_level),
    .irq_raw(irq_raw), .irq_clr(irq_clr), .irq(irq)
);

// File: tb/test_byte_q_irq_top.sv
`timescale 1ns/1ps
module test_byte_q_irq_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic rx_push = 0, rx_pop = 0, rx_flush = 0;
    logic tx_push = 0, tx_pop = 0, tx_flush = 0;
    logic [7:0] rx_wdata = 0, tx_wdata = 0, rx_rdata, tx_rdata;
    logic [4:0] rx_level, tx_level;
    logic [3:0] rx_mark = 4'd4, tx_mark = 4'd2;
    logic wd_trigger = 0, wd_repeat = 0;
    logic [15:0] wd_limit = 16'd20;
    logic [4:0] irq_en = 0, irq_clr = 0, irq_raw, irq_masked;
    logic irq;

    byte_q_irq_top i_byte_q_irq_top (
        .clk(clk), .rst_n(rst_n),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_flush(rx_flush),
        .rx_rdata(rx_rdata), .rx_level(rx_level),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_flush(tx_flush),
        .tx_rdata(tx_rdata), .tx_level(tx_level),
        .rx_mark(rx_mark), .tx_mark(tx_mark),
        .wd_trigger(wd_trigger), .wd_repeat(wd_repeat), .wd_limit(wd_limit),
        .irq_en(irq_en), .irq_clr(irq_clr),
        .irq_raw(irq_raw), .irq_masked(irq_masked), .irq(irq)
    );

    int n_cmp = 0, n_bad = 0;
    logic [7:0] rxq[$], txq[$];

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitors: compare popped bytes with the scoreboard queues
    always @(posedge clk) begin
        if (rst_n && rx_pop && !rx_flush && rx_level != 0) begin
            @(negedge clk);
            if (rxq.size() == 0) check("R1 rx scoreboard empty", 1, 0);
            else check("R1 rx order", {24'd0, rx_rdata}, {24'd0, rxq.pop_front()});
        end
    end
    always @(posedge clk) begin
        if (rst_n && tx_pop && !tx_flush && tx_level != 0) begin
            @(negedge clk);
            if (txq.size() == 0) check("R1 tx scoreboard empty", 1, 0);
            else check("R1 tx order", {24'd0, tx_rdata}, {24'd0, txq.pop_front()});
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic rx_put(logic [7:0] v);
        @(negedge clk);
        if (rxq.size() < 16) rxq.push_back(v);
        rx_push = 1; rx_wdata = v;
        @(negedge clk);
        rx_push = 0;
    endtask
    task automatic tx_put(logic [7:0] v);
        @(negedge clk);
        if (txq.size() < 16) txq.push_back(v);
        tx_push = 1; tx_wdata = v;
        @(negedge clk);
        tx_push = 0;
    endtask
    task automatic rx_get();
        @(negedge clk); rx_pop = 1;
        @(negedge clk); rx_pop = 0;
    endtask
    task automatic tx_get();
        @(negedge clk); tx_pop = 1;
        @(negedge clk); tx_pop = 0;
    endtask
    task automatic clr(logic [4:0] v);
        @(negedge clk); irq_clr = v;
        @(negedge clk); irq_clr = 0;
    endtask
    task automatic trig();
        @(negedge clk); wd_trigger = 1;
        @(negedge clk); wd_trigger = 0;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog run did not complete actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] last;
        idle(3);
        // R12 reset state
        check("R12 rx level", rx_level, 0);
        check("R12 tx level", tx_level, 0);
        check("R12 raw", irq_raw, 0);
        rst_n = 1;
        idle(2);

        // R4 threshold at mark 4
        for (int i = 0; i < 3; i++) rx_put(8'h10 + 8'(i));
        idle(2);
        check("R4 below mark", irq_raw[0], 0);
        rx_put(8'h13);
        idle(2);
        check("R4 at mark", irq_raw[0], 1);
        check("R10 disabled irq", irq, 0);
        @(negedge clk); irq_en = 5'h01;
        idle(1);
        check("R10 masked", irq_masked, 5'h01);
        check("R10 irq", irq, 1);
        clr(5'h01);
        idle(1);
        check("R11 set wins rx", irq_raw[0], 1);
        for (int i = 0; i < 4; i++) rx_get();
        clr(5'h01);
        idle(1);
        check("R11 clear", irq_raw[0], 0);
        @(negedge clk); irq_en = 0; rx_mark = 4'd0;

        // R4 mark 0 means 16, R2 overflow
        for (int i = 0; i < 15; i++) rx_put(8'h40 + 8'(i));
        idle(2);
        check("R4 mark0 at 15", irq_raw[0], 0);
        rx_put(8'h4F);
        idle(2);
        check("R4 mark0 at 16", irq_raw[0], 1);
        rx_put(8'hEE);
        idle(1);
        check("R2 rx level stays", rx_level, 16);
        check("R2 rx ovf bit", irq_raw[2], 1);
        for (int i = 0; i < 16; i++) rx_get();
        idle(2);
        last = rx_rdata;
        rx_get();
        idle(1);
        check("R3 empty pop data", rx_rdata, last);
        check("R3 empty pop level", rx_level, 0);

        // R5 transmit threshold, mark 2
        check("R5 tx empty at 0", irq_raw[1], 1);
        clr(5'h02);
        idle(1);
        check("R11 set wins tx", irq_raw[1], 1);
        for (int i = 0; i < 5; i++) tx_put(8'hA0 + 8'(i));
        clr(5'h02);
        idle(2);
        check("R5 above mark", irq_raw[1], 0);
        tx_get(); tx_get();
        idle(2);
        check("R5 level 3", irq_raw[1], 0);
        tx_get();
        idle(2);
        check("R5 level 2", irq_raw[1], 1);

        // R9 flush one side only
        rx_put(8'h77);
        @(negedge clk); tx_flush = 1;
        @(negedge clk); tx_flush = 0;
        txq.delete();
        check("R9 tx flushed", tx_level, 0);
        check("R9 rx untouched", rx_level, 1);
        check("R9 tx data kept", tx_rdata, 8'hA2);

        // R2 transmit overflow
        for (int i = 0; i < 17; i++) tx_put(8'hC0 + 8'(i));
        idle(1);
        check("R2 tx level stays", tx_level, 16);
        check("R2 tx ovf bit", irq_raw[3], 1);
        for (int i = 0; i < 16; i++) tx_get();
        rx_get();
        idle(2);
        clr(5'h1F);
        @(negedge clk); rx_mark = 4'd4;

        // R7 empty queue holds watchdog
        trig();
        idle(40);
        check("R7 empty no fire", irq_raw[4], 0);
        rx_put(8'h01); rx_put(8'h02);
        idle(10);
        check("R7 quiet 10", irq_raw[4], 0);
        rx_put(8'h03);
        idle(14);
        check("R7 restart on push", irq_raw[4], 0);
        idle(10);
        check("R6 timeout fires", irq_raw[4], 1);
        clr(5'h10);
        idle(40);
        check("R8 single shot", irq_raw[4], 0);

        // R8 repeat mode
        @(negedge clk); wd_repeat = 1;
        trig();
        idle(24);
        check("R8 repeat first", irq_raw[4], 1);
        clr(5'h10);
        idle(20);
        check("R8 repeat second", irq_raw[4], 1);

        // R9 receive flush, then R7 with empty queue
        last = rx_rdata;
        @(negedge clk); rx_flush = 1; rx_push = 1; rx_wdata = 8'h99;
        @(negedge clk); rx_flush = 0; rx_push = 0;
        rxq.delete();
        check("R9 rx flushed", rx_level, 0);
        check("R9 rx data kept", rx_rdata, last);
        clr(5'h10);
        idle(30);
        check("R7 flushed no fire", irq_raw[4], 0);

        idle(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule